// File: doc/BRIEF.md
# Interpolating Synthesizer Bank with Cross-Modulation

A bank of numerically controlled sine oscillators. Each channel adds a tuning word to a 32-bit phase register on every clock. The upper phase bits select an entry in a sine table. The next eight bits linearly interpolate between that entry and its neighbour, so a new interpolated sample is produced each cycle. Each channel drives a signed 16-bit amplitude word. It also drives a square-wave bit, which is the top bit of its phase register and can be used on-chip without a converter.

Any channel can take another channel's registered amplitude as a modulation source. The source then changes its frequency (FM), its phase (PM) or its gain (AM). Modulated channels can themselves modulate further channels, which forms chained paths. The source value is always the source's registered output from the previous clock, so chained paths never form combinational loops. Configuration is written one field per cycle through a flat write port.

Top module: `dds_bank`

## Requirements
- R1: While rst_ni is low, every amplitude word, every square bit and valid_o are zero. After rst_ni is released, valid_o goes high at the third rising edge and stays high.
- R2: After each rising edge, a channel's phase equals its previous phase plus its tuning word (plus the FM term), modulo 2^32. sq_o[c] is bit 31 of that phase. A tuning-word write changes the step from the following edge and leaves the accumulated phase untouched.
- R3: Table entry k (0..1023) equals floor(32767*sin(2*pi*k/1024) + 0.5).
- R4: The amplitude word after edge n comes from the phase p held after edge n-3 (plus the PM term). With i = p[31:22] and f = p[21:14], the word is T[i] + floor((T[(i+1) mod 1024] - T[i]) * f / 256).
- R5: A write takes effect at a rising edge while wr_en_i is high, on channel wr_ch_i. wr_sel_i selects the field: 0 is the tuning word (wr_data_i[31:0]); 1 is routing, with mode in wr_data_i[1:0] (0 none, 1 AM, 2 FM, 3 PM) and source channel in wr_data_i[9:8]; 2 is the signed depth in wr_data_i[15:0].
- R6: In FM mode the product depth*src (signed, 32 bits) is added to the tuning word for that clock's phase step.
- R7: In PM mode depth*src is added to the phase before the table lookup, without changing the stored phase.
- R8: In AM mode the output is s + floor(s*depth*src / 2^30), saturated to [-32768, 32767], where s is the interpolated sample. In any other mode the output is s.
- R9: src is the source channel's amplitude word as registered after the previous edge. A channel whose source index names itself, or names no existing channel, is unmodulated.
- R10: Modulation chains: a channel under modulation may serve as the source for another channel, and each link follows R6 to R9.
- R11: Writes to a channel index of 3 or more change no channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_ch_i | input | 2 | Target channel of the write |
| wr_sel_i | input | 2 | Field select: tuning, routing, depth |
| wr_data_i | input | 32 | Write data |
| amp_o | output | 48 | Three signed 16-bit amplitude words, channel 0 in the low bits |
| sq_o | output | 3 | Square-wave bit per channel (phase MSB) |
| valid_o | output | 1 | High once the pipeline holds meaningful samples |

## Verification
A corrupted phase register shows at once on sq_o. Its effect reaches the amplitude words exactly three edges later, and the error persists, because the phase integrates every later step. A wrong table word or interpolation weight shows as a single-sample error three edges after the phase that indexes it. A full-table sweep at one entry per clock exposes any bad entry within 1024 cycles. A routing fault changes the modulated channel's output from the first sample that uses a nonzero source value. It also propagates down a chain one register stage per link.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_AM   = 2'd1,
    MOD_FM   = 2'd2,
    MOD_PM   = 2'd3
  } mod_e;

  function automatic int sine_entry(input int k, input int n, input int amp);
    real x;
    x = real'(amp) * $sin(2.0 * 3.141592653589793 * real'(k) / real'(n));
    return $rtoi($floor(x + 0.5));
  endfunction
endpackage

// File: rtl/dds_rom.sv
module dds_rom #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic [ADDR_W-1:0]       addr_a_i,
  input  logic [ADDR_W-1:0]       addr_b_i,
  output logic signed [AMP_W-1:0] data_a_o,
  output logic signed [AMP_W-1:0] data_b_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign mem[k] = AMP_W'(dds_pkg::sine_entry(k, DEPTH, AMP_MAX));
  end

  assign data_a_o = mem[addr_a_i];
  assign data_b_o = mem[addr_b_i];
endmodule

// File: rtl/dds_channel.sv
module dds_channel
  import dds_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int AMP_W   = 16,
  parameter int DEPTH_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PHASE_W-1:0]        ftw_i,
  input  mod_e                      mode_i,
  input  logic signed [DEPTH_W-1:0] depth_i,
  input  logic signed [AMP_W-1:0]   src_amp_i,
  input  logic                      use_mod_i,
  output logic signed [AMP_W-1:0]   amp_o,
  output logic                      sq_o
);
  localparam int PROD_W   = DEPTH_W + AMP_W;
  localparam int FULL_W   = PROD_W + AMP_W;
  localparam int AM_SHIFT = PROD_W - 2;
  localparam int FSHIFT   = PHASE_W - ADDR_W - FRAC_W;
  localparam logic signed [FULL_W-1:0] SAT_HI = FULL_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [FULL_W-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [PROD_W-1:0] prod_raw, prod;
  logic [PHASE_W-1:0] prod_ext, fm_add, pm_add, acc_q, phase_m;
  logic [ADDR_W-1:0] idx, idx_n;
  logic [FRAC_W-1:0] frac, frac_q;
  logic signed [AMP_W-1:0] rom_a, rom_b, a_q, b_q, interp_d, interp_q, amp_d, amp_q;
  logic signed [AMP_W:0] diff;
  logic signed [AMP_W+FRAC_W+1:0] step;
  logic signed [FULL_W-1:0] am_full, am_sum;

  assign prod_raw = depth_i * src_amp_i;
  assign prod     = use_mod_i ? prod_raw : '0;
  assign prod_ext = PHASE_W'(prod);
  assign fm_add   = (mode_i == MOD_FM) ? prod_ext : '0;
  assign pm_add   = (mode_i == MOD_PM) ? prod_ext : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_i + fm_add;
  end

  // stage 1: table fetch
  assign phase_m = acc_q + pm_add;
  assign idx     = phase_m[PHASE_W-1 -: ADDR_W];
  assign frac    = FRAC_W'(phase_m >> FSHIFT);
  assign idx_n   = idx + 1'b1;

  dds_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addr_a_i(idx),
    .addr_b_i(idx_n),
    .data_a_o(rom_a),
    .data_b_o(rom_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      frac_q <= '0;
    end else begin
      a_q    <= rom_a;
      b_q    <= rom_b;
      frac_q <= frac;
    end
  end

  // stage 2: interpolation
  assign diff     = b_q - a_q;
  assign step     = diff * $signed({1'b0, frac_q});
  assign interp_d = a_q + AMP_W'(step >>> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) interp_q <= '0;
    else         interp_q <= interp_d;
  end

  // stage 3: gain modulation with saturation
  assign am_full = interp_q * prod;
  assign am_sum  = interp_q + (am_full >>> AM_SHIFT);

  always_comb begin
    amp_d = interp_q;
    if (mode_i == MOD_AM) begin
      if (am_sum > SAT_HI)      amp_d = AMP_W'(SAT_HI);
      else if (am_sum < SAT_LO) amp_d = AMP_W'(SAT_LO);
      else                      amp_d = AMP_W'(am_sum);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= '0;
    else         amp_q <= amp_d;
  end

  assign amp_o = amp_q;
  assign sq_o  = acc_q[PHASE_W-1];

  logic signed [AMP_W-1:0] lo_v, hi_v;
  assign lo_v = (a_q < b_q) ? a_q : b_q;
  assign hi_v = (a_q < b_q) ? b_q : a_q;

  // R4
  interp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (interp_q >= $past(lo_v)) && (interp_q <= $past(hi_v)));

  // R8
  am_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MOD_AM) |=> (amp_o == $past(interp_q)));
endmodule

// File: rtl/dds_bank.sv
module dds_bank
  import dds_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int AMP_W   = 16,
  parameter int DEPTH_W = 16,
  parameter int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [CH_W-1:0]        wr_ch_i,
  input  logic [1:0]             wr_sel_i,
  input  logic [PHASE_W-1:0]     wr_data_i,
  output logic [NCH*AMP_W-1:0]   amp_o,
  output logic [NCH-1:0]         sq_o,
  output logic                   valid_o
);
  localparam int LAT   = 3;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [PHASE_W-1:0]        ftw_q   [NCH];
  mod_e                      mode_q  [NCH];
  logic [CH_W-1:0]           src_q   [NCH];
  logic signed [DEPTH_W-1:0] depth_q [NCH];
  logic signed [AMP_W-1:0]   amp_w   [NCH];
  logic signed [AMP_W-1:0]   src_amp [NCH];
  logic [NCH-1:0]            use_mod;
  logic [CNT_W-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        ftw_q[c]   <= '0;
        mode_q[c]  <= MOD_NONE;
        src_q[c]   <= '0;
        depth_q[c] <= '0;
      end
    end else if (wr_en_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_ch_i == CH_W'(c)) begin
          case (wr_sel_i)
            2'd0: ftw_q[c] <= wr_data_i;
            2'd1: begin
              mode_q[c] <= mod_e'(wr_data_i[1:0]);
              src_q[c]  <= wr_data_i[8 +: CH_W];
            end
            2'd2: depth_q[c] <= wr_data_i[DEPTH_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // source select: registered neighbour output, self or absent index disables
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      src_amp[c] = '0;
      use_mod[c] = 1'b0;
      for (int k = 0; k < NCH; k++) begin
        if (src_q[c] == CH_W'(k)) begin
          src_amp[c] = amp_w[k];
          use_mod[c] = (k != c);
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dds_channel #(
      .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
      .AMP_W(AMP_W), .DEPTH_W(DEPTH_W)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ftw_i    (ftw_q[c]),
      .mode_i   (mode_q[c]),
      .depth_i  (depth_q[c]),
      .src_amp_i(src_amp[c]),
      .use_mod_i(use_mod[c]),
      .amp_o    (amp_w[c]),
      .sq_o     (sq_o[c])
    );
    assign amp_o[c*AMP_W +: AMP_W] = amp_w[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q != CNT_W'(LAT)) cnt_q <= cnt_q + 1'b1;
  end
  assign valid_o = (cnt_q == CNT_W'(LAT));

  // R1
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  // R1
  warmup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (amp_o == '0));
endmodule

// File: tb/dds_bank_tb.sv
`timescale 1ns/1ps
module dds_bank_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [47:0] amp;
  logic [2:0]  sq;
  logic        valid;

  always #10 clk = ~clk;

  dds_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .amp_o(amp), .sq_o(sq), .valid_o(valid)
  );

  int total = 0;
  int bad = 0;

  int tab [1024];
  logic [31:0] m_acc [NCH];
  int m_a [NCH], m_b [NCH], m_f [NCH], m_s2 [NCH], m_out [NCH];
  int vcnt;
  logic [31:0] c_ftw [NCH];
  int c_mode [NCH], c_src [NCH], c_depth [NCH];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_step();
    int prod [NCH];
    logic [31:0] n_acc [NCH];
    int n_a [NCH], n_b [NCH], n_f [NCH], n_s2 [NCH], n_out [NCH];
    for (int c = 0; c < NCH; c++) begin
      bit use_m;
      use_m = (c_src[c] < NCH) && (c_src[c] != c);
      prod[c] = use_m ? c_depth[c] * m_out[c_src[c]] : 0;
    end
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] ph;
      int idx;
      n_acc[c] = m_acc[c] + c_ftw[c] + ((c_mode[c] == 2) ? 32'(prod[c]) : 32'd0);
      ph = m_acc[c] + ((c_mode[c] == 3) ? 32'(prod[c]) : 32'd0);
      idx = int'(ph[31:22]);
      n_a[c] = tab[idx];
      n_b[c] = tab[(idx + 1) % 1024];
      n_f[c] = int'(ph[21:14]);
      n_s2[c] = m_a[c] + (((m_b[c] - m_a[c]) * m_f[c]) >>> 8);
      if (c_mode[c] == 1)
        n_out[c] = sat16(longint'(m_s2[c]) + ((longint'(m_s2[c]) * longint'(prod[c])) >>> 30));
      else
        n_out[c] = m_s2[c];
    end
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = n_acc[c]; m_a[c] = n_a[c]; m_b[c] = n_b[c];
      m_f[c] = n_f[c]; m_s2[c] = n_s2[c]; m_out[c] = n_out[c];
    end
    if (vcnt < 3) vcnt++;
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < NCH; c++) begin
      int a;
      a = int'($signed(amp[c*16 +: 16]));
      chk(a == m_out[c], $sformatf("%s amp ch%0d", tag, c), a, m_out[c]);
      chk(sq[c] == m_acc[c][31], $sformatf("%s sq ch%0d", tag, c), int'(sq[c]), int'(m_acc[c][31]));
    end
    chk(valid == (vcnt == 3), $sformatf("%s valid", tag), int'(valid), int'(vcnt == 3));
  endtask

  task automatic cyc(input bit we, input int ch, input int sel, input logic [31:0] d, input string tag);
    wr_en = we; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = d;
    @(posedge clk);
    #1;
    model_step();
    if (we && ch < NCH) begin
      case (sel)
        0: c_ftw[ch] = d;
        1: begin c_mode[ch] = int'(d[1:0]); c_src[ch] = int'(d[9:8]); end
        2: c_depth[ch] = int'($signed(d[15:0]));
        default: ;
      endcase
    end
    wr_en = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 32'd0, tag);
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d, input string tag);
    cyc(1'b1, ch, sel, d, tag);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++)
      tab[k] = $rtoi($floor(32767.0 * $sin(2.0 * 3.141592653589793 * k / 1024.0) + 0.5));
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = '0; m_a[c] = 0; m_b[c] = 0; m_f[c] = 0; m_s2[c] = 0; m_out[c] = 0;
      c_ftw[c] = '0; c_mode[c] = 0; c_src[c] = 0; c_depth[c] = 0;
    end
    vcnt = 0;

    // R3: spot values of the table formula
    chk(tab[256] == 32767, "R3 tab quarter", tab[256], 32767);
    chk(tab[768] == -32767, "R3 tab three-quarter", tab[768], -32767);

    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    chk(amp == '0, "R1 reset amp", int'(amp[15:0]), 0);
    chk(sq == '0, "R1 reset sq", int'(sq), 0);
    chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    rst_ni = 1'b1;
    run(5, "R1");

    // R3: one table entry per clock, whole table
    wr(0, 0, 32'h0040_0000, "R5");
    run(1030, "R3");

    // R4 and R5: interpolated sweeps on all channels
    wr(0, 0, 32'h0123_4567, "R5");
    wr(1, 0, 32'h0A00_1234, "R5");
    wr(2, 0, 32'hF13A_5C01, "R5");
    run(300, "R4");

    // R2: phase-continuous tuning change
    wr(1, 0, 32'h3000_0000, "R2");
    run(60, "R2");
    wr(1, 0, 32'h0000_0001, "R2");
    run(40, "R2");

    // R6: FM from a quarter-rate source
    wr(0, 0, 32'h4000_0000, "R6");
    wr(1, 0, 32'h0200_0000, "R6");
    wr(1, 2, 32'd2000, "R5");
    wr(1, 1, 32'h0000_0002, "R5");
    run(200, "R6");

    // R7 and R10: PM on ch2 from FM-modulated ch1
    wr(2, 0, 32'h0200_0000, "R7");
    wr(2, 2, 32'd20000, "R7");
    wr(2, 1, 32'h0000_0103, "R7");
    run(200, "R7");
    wr(1, 2, 32'h0000_8000, "R10");
    run(200, "R10");

    // R8: AM, moderate and saturating, then negative depth
    wr(1, 1, 32'h0000_0001, "R8");
    wr(1, 2, 32'd16384, "R8");
    run(200, "R8");
    wr(1, 2, 32'h0000_7FFF, "R8");
    run(150, "R8");
    wr(1, 2, 32'h0000_8000, "R8");
    run(150, "R8");

    // R9: self source and absent source
    wr(2, 1, 32'h0000_0202, "R9");
    run(100, "R9");
    wr(2, 1, 32'h0000_0303, "R9");
    run(100, "R9");

    // R11: writes to a channel that does not exist
    wr(3, 0, 32'hDEAD_BEEF, "R11");
    wr(3, 1, 32'h0000_0003, "R11");
    wr(3, 2, 32'h0000_7FFF, "R11");
    run(100, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule